// File: doc/BRIEF.md
# Averaging Sensor Conversion Controller

This block sits between a processor register bus and the 12-bit ADC of an on-chip temperature sensor. Software powers the sensor through a supply register, waits out a settling time that the block enforces, selects an averaging depth and the output source in a mode register, and fires a conversion with a trigger register. The controller then requests samples over a request/valid handshake, sums them, and stores either the truncated mean or the last raw code as the result.

Each finished result is checked once against a programmable low/high window. A result outside the window raises a compare flag, and the interrupt output follows that flag when it is unmasked. Both the conversion-done flag and the compare flag are cleared by writing ones to a dedicated clear register. A continuous mode keeps restarting conversions until it is switched off. Removing power aborts any conversion in flight.

Top module: `tsense_avg_ctrl`

## Requirements
- R1: After reset every readable register reads 0, `smp_req` is 0 and `cmp_irq` is 0.
- R2: A write to the supply register (offset 0x00) stores bits 2:0 only when bit 2 (subsystem enable) is 1 in the written value; otherwise the register becomes 0. The sensor counts as powered when bit 0 (sensor enable) and bit 2 are 1 and bit 1 (ADC power-down) is 0.
- R3: A trigger is ignored while the sensor is unpowered and during the first `SETTLE_CYC` clock cycles after it becomes powered.
- R4: Writing 1 to bit 0 of the trigger register (0x04) starts one conversion; bit 0 of the status register (0x14) reads 1 while it runs; a trigger written during a conversion is ignored.
- R5: Mode register (0x08) bits 1:0 hold m; a conversion takes 2^m samples. With bit 9 set, the result register (0x10, bits 11:0) receives the sample sum shifted right by m, truncated.
- R6: With mode bit 9 clear, the result is the last sample code of the conversion.
- R7: At the end of a conversion bit 0 of the flag register (0x30) is set. Writing the clear register (0x38) with bit 0 set clears it; bit 1 of that write clears only the compare flag, and zero bits leave flags unchanged.
- R8: When bit 0 of the compare register (0x18) is set, bit 1 of the flag register is set at the end of a conversion whose result is below the low limit (0x1C) or above the high limit (0x20); limits are inclusive, and nothing is set with compare disabled.
- R9: `cmp_irq` is high exactly when the compare flag and bit 1 of the interrupt enable register (0x34) are both set.
- R10: With mode bit 4 set, each finished conversion is followed at once by another; clearing bit 4 lets the running one finish and no further one starts.
- R11: A supply write that leaves the sensor unpowered aborts a running conversion: busy clears and no done flag is raised.
- R12: A sample is taken only in a cycle where `smp_req` and `smp_vld` are both high; `smp_req` is high while a conversion runs, and a conversion takes exactly 2^m samples.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| bus_sel | input | 1 | Register access select |
| bus_wr | input | 1 | 1 = write, 0 = read |
| bus_addr | input | 8 | Byte offset of the register |
| bus_wdata | input | 32 | Write data |
| bus_rdata | output | 32 | Read data, combinational from the address |
| smp_req | output | 1 | Sample request to the ADC |
| smp_vld | input | 1 | ADC sample valid |
| smp_code | input | 12 | ADC sample code |
| cmp_irq | output | 1 | Window-compare interrupt |

## Verification
A register write takes effect at the clock edge it is presented on, so busy, supply and flag values are read back at the following falling edge; the interrupt output is combinational from registered state and is sampled in the same way. The result, done flag and compare flag all update at the very edge that accepts the last sample, so the bench polls the done flag and reads the result only once it is seen. The settling window is probed a fixed number of cycles before and after its end, and the sample stub counts accepted handshakes so every conversion is checked for exactly 2^m samples.

// File: rtl/tsa_pkg.sv
package tsa_pkg;
  // Register byte offsets; software depends on these values.
  localparam logic [7:0] OFS_SUPPLY = 8'h00;
  localparam logic [7:0] OFS_TRIG   = 8'h04;
  localparam logic [7:0] OFS_MODE   = 8'h08;
  localparam logic [7:0] OFS_RESULT = 8'h10;
  localparam logic [7:0] OFS_STAT   = 8'h14;
  localparam logic [7:0] OFS_CMP    = 8'h18;
  localparam logic [7:0] OFS_LOW    = 8'h1C;
  localparam logic [7:0] OFS_HIGH   = 8'h20;
  localparam logic [7:0] OFS_FLAGS  = 8'h30;
  localparam logic [7:0] OFS_IEN    = 8'h34;
  localparam logic [7:0] OFS_CLR    = 8'h38;

  // Mode register bit positions
  localparam int MODE_CONT_BIT = 4;
  localparam int MODE_AVG_BIT  = 9;

  typedef enum logic [0:0] {SQ_IDLE = 1'b0, SQ_RUN = 1'b1} sq_state_e;
endpackage

// File: rtl/tsa_settle.sv
module tsa_settle #(
  parameter int SETTLE_CYC = 120
) (
  input  logic clk,
  input  logic rst_n,
  input  logic pwr_on_i,
  output logic ready_o
);
  localparam int CW = $clog2(SETTLE_CYC + 1);
  localparam logic [CW-1:0] LIMIT = CW'(SETTLE_CYC);

  logic [CW-1:0] cnt_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cnt_q <= '0;
    end else if (!pwr_on_i) begin
      cnt_q <= '0;
    end else if (cnt_q != LIMIT) begin
      cnt_q <= cnt_q + 1'b1;
    end
  end

  assign ready_o = pwr_on_i && (cnt_q == LIMIT);
endmodule

// File: rtl/tsa_seq.sv
module tsa_seq
  import tsa_pkg::*;
#(
  parameter int CODE_W      = 12,
  parameter int AVG_LOG_MAX = 3,
  localparam int LW = (AVG_LOG_MAX < 2) ? 1 : $clog2(AVG_LOG_MAX + 1)
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              start_i,
  input  logic              abort_i,
  input  logic              cont_i,
  input  logic [LW-1:0]     avg_log_i,
  input  logic              use_avg_i,
  input  logic              smp_vld_i,
  input  logic [CODE_W-1:0] smp_code_i,
  output logic              smp_req_o,
  output logic              busy_o,
  output logic              fin_o,
  output logic [CODE_W-1:0] res_o
);
  localparam int SUM_W = CODE_W + AVG_LOG_MAX;
  localparam int CW    = AVG_LOG_MAX + 1;

  // Truncating mean: drop the low sh bits of the sum.
  function automatic logic [CODE_W-1:0] avg_of(input logic [SUM_W-1:0] s,
                                               input logic [LW-1:0] sh);
    logic [SUM_W-1:0] t;
    t = s >> sh;
    return t[CODE_W-1:0];
  endfunction

  // Index of the final sample for a depth of 2^sh.
  function automatic logic [CW-1:0] last_idx(input logic [LW-1:0] sh);
    logic [CW-1:0] one;
    one = 1;
    return (one << sh) - 1'b1;
  endfunction

  function automatic logic [LW-1:0] clamp_log(input logic [LW-1:0] v);
    return (int'(v) > AVG_LOG_MAX) ? LW'(AVG_LOG_MAX) : v;
  endfunction

  sq_state_e        st_q;
  logic [SUM_W-1:0] acc_q;
  logic [CW-1:0]    cnt_q;
  logic [LW-1:0]    lg_q;
  logic             avg_q;

  logic             take;
  logic             last;
  logic [SUM_W-1:0] sum_nx;

  assign busy_o    = (st_q == SQ_RUN);
  assign smp_req_o = busy_o;
  assign take      = busy_o && smp_vld_i;
  assign last      = take && (cnt_q == last_idx(lg_q));
  assign sum_nx    = acc_q + SUM_W'(smp_code_i);
  assign fin_o     = last && !abort_i;
  assign res_o     = avg_q ? avg_of(sum_nx, lg_q) : smp_code_i;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st_q  <= SQ_IDLE;
      acc_q <= '0;
      cnt_q <= '0;
      lg_q  <= '0;
      avg_q <= 1'b0;
    end else if (abort_i) begin
      st_q  <= SQ_IDLE;
      acc_q <= '0;
      cnt_q <= '0;
    end else begin
      case (st_q)
        SQ_IDLE: begin
          if (start_i) begin
            st_q  <= SQ_RUN;
            acc_q <= '0;
            cnt_q <= '0;
            lg_q  <= clamp_log(avg_log_i);
            avg_q <= use_avg_i;
          end
        end
        SQ_RUN: begin
          if (last) begin
            acc_q <= '0;
            cnt_q <= '0;
            if (cont_i) begin
              lg_q  <= clamp_log(avg_log_i);
              avg_q <= use_avg_i;
            end else begin
              st_q <= SQ_IDLE;
            end
          end else if (take) begin
            acc_q <= sum_nx;
            cnt_q <= cnt_q + 1'b1;
          end
        end
        default: st_q <= SQ_IDLE;
      endcase
    end
  end
endmodule

// File: rtl/tsa_regs.sv
module tsa_regs
  import tsa_pkg::*;
#(
  parameter int AW     = 8,
  parameter int DW     = 32,
  parameter int CODE_W = 12,
  parameter int LW     = 2
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              sel_i,
  input  logic              wr_i,
  input  logic [AW-1:0]     addr_i,
  input  logic [DW-1:0]     wdata_i,
  output logic [DW-1:0]     rdata_o,
  input  logic              busy_i,
  input  logic              ready_i,
  input  logic              fin_i,
  input  logic [CODE_W-1:0] res_i,
  output logic              start_o,
  output logic              pwr_ok_o,
  output logic [LW-1:0]     avg_log_o,
  output logic              cont_o,
  output logic              use_avg_o,
  output logic              cmp_en_o,
  output logic              cmp_hit_o,
  output logic              flag_done_o,
  output logic              flag_cmp_o,
  output logic              irq_o
);
  function automatic logic outside(input logic [CODE_W-1:0] c,
                                   input logic [CODE_W-1:0] lo,
                                   input logic [CODE_W-1:0] hi);
    return (c < lo) || (c > hi);
  endfunction

  function automatic logic hit(input logic [AW-1:0] a, input logic [7:0] ofs);
    return a == AW'(ofs);
  endfunction

  logic [2:0]        sup_q;
  logic [LW-1:0]     mlog_q;
  logic              mcont_q;
  logic              mavg_q;
  logic              cen_q;
  logic [CODE_W-1:0] lo_q;
  logic [CODE_W-1:0] hi_q;
  logic              ie_q;
  logic              fd_q;
  logic              fc_q;
  logic [CODE_W-1:0] res_q;

  logic we;
  logic clr_done;
  logic clr_cmp;
  logic unused_wbits;

  assign we           = sel_i && wr_i;
  assign clr_done     = we && hit(addr_i, OFS_CLR) && wdata_i[0];
  assign clr_cmp      = we && hit(addr_i, OFS_CLR) && wdata_i[1];
  assign unused_wbits = ^wdata_i;

  assign pwr_ok_o  = sup_q[0] && sup_q[2] && !sup_q[1];
  assign start_o   = we && hit(addr_i, OFS_TRIG) && wdata_i[0] && !busy_i && ready_i;
  assign cmp_hit_o = fin_i && cen_q && outside(res_i, lo_q, hi_q);

  assign avg_log_o   = mlog_q;
  assign cont_o      = mcont_q;
  assign use_avg_o   = mavg_q;
  assign cmp_en_o    = cen_q;
  assign flag_done_o = fd_q;
  assign flag_cmp_o  = fc_q;
  assign irq_o       = fc_q && ie_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      sup_q   <= '0;
      mlog_q  <= '0;
      mcont_q <= 1'b0;
      mavg_q  <= 1'b0;
      cen_q   <= 1'b0;
      lo_q    <= '0;
      hi_q    <= '0;
      ie_q    <= 1'b0;
      fd_q    <= 1'b0;
      fc_q    <= 1'b0;
      res_q   <= '0;
    end else begin
      if (we && hit(addr_i, OFS_SUPPLY)) begin
        sup_q <= wdata_i[2] ? wdata_i[2:0] : 3'b000;
      end
      if (we && hit(addr_i, OFS_MODE)) begin
        mlog_q  <= wdata_i[LW-1:0];
        mcont_q <= wdata_i[MODE_CONT_BIT];
        mavg_q  <= wdata_i[MODE_AVG_BIT];
      end
      if (we && hit(addr_i, OFS_CMP))  cen_q <= wdata_i[0];
      if (we && hit(addr_i, OFS_LOW))  lo_q  <= wdata_i[CODE_W-1:0];
      if (we && hit(addr_i, OFS_HIGH)) hi_q  <= wdata_i[CODE_W-1:0];
      if (we && hit(addr_i, OFS_IEN))  ie_q  <= wdata_i[1];
      if (fin_i) res_q <= res_i;
      // A new event wins over a clear in the same cycle.
      fd_q <= (fd_q && !clr_done) || fin_i;
      fc_q <= (fc_q && !clr_cmp) || cmp_hit_o;
    end
  end

  always_comb begin
    rdata_o = '0;
    if (sel_i && !wr_i) begin
      if (hit(addr_i, OFS_SUPPLY)) rdata_o[2:0] = sup_q;
      if (hit(addr_i, OFS_MODE)) begin
        rdata_o[LW-1:0]        = mlog_q;
        rdata_o[MODE_CONT_BIT] = mcont_q;
        rdata_o[MODE_AVG_BIT]  = mavg_q;
      end
      if (hit(addr_i, OFS_RESULT)) rdata_o[CODE_W-1:0] = res_q;
      if (hit(addr_i, OFS_STAT))   rdata_o[0] = busy_i;
      if (hit(addr_i, OFS_CMP))    rdata_o[0] = cen_q;
      if (hit(addr_i, OFS_LOW))    rdata_o[CODE_W-1:0] = lo_q;
      if (hit(addr_i, OFS_HIGH))   rdata_o[CODE_W-1:0] = hi_q;
      if (hit(addr_i, OFS_FLAGS))  rdata_o[1:0] = {fc_q, fd_q};
      if (hit(addr_i, OFS_IEN))    rdata_o[1] = ie_q;
    end
  end
endmodule

// File: rtl/tsense_avg_ctrl.sv
module tsense_avg_ctrl #(
  parameter int AW          = 8,
  parameter int DW          = 32,
  parameter int CODE_W      = 12,
  parameter int AVG_LOG_MAX = 3,
  parameter int SETTLE_CYC  = 120
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              bus_sel,
  input  logic              bus_wr,
  input  logic [AW-1:0]     bus_addr,
  input  logic [DW-1:0]     bus_wdata,
  output logic [DW-1:0]     bus_rdata,
  output logic              smp_req,
  input  logic              smp_vld,
  input  logic [CODE_W-1:0] smp_code,
  output logic              cmp_irq
);
  localparam int LW = (AVG_LOG_MAX < 2) ? 1 : $clog2(AVG_LOG_MAX + 1);

  // Internal events, named for the checker.
  logic              start_evt;
  logic              fin_evt;
  logic              busy;
  logic              pwr_ok;
  logic              settle_ok;
  logic              flag_done;
  logic              flag_cmp;
  logic              cmp_en;
  logic              cmp_hit;
  logic [LW-1:0]     avg_log;
  logic              cont;
  logic              use_avg;
  logic [CODE_W-1:0] new_res;

  tsa_regs #(.AW(AW), .DW(DW), .CODE_W(CODE_W), .LW(LW)) u_regs (
    .clk(clk), .rst_n(rst_n),
    .sel_i(bus_sel), .wr_i(bus_wr), .addr_i(bus_addr), .wdata_i(bus_wdata),
    .rdata_o(bus_rdata),
    .busy_i(busy), .ready_i(settle_ok), .fin_i(fin_evt), .res_i(new_res),
    .start_o(start_evt), .pwr_ok_o(pwr_ok), .avg_log_o(avg_log),
    .cont_o(cont), .use_avg_o(use_avg), .cmp_en_o(cmp_en), .cmp_hit_o(cmp_hit),
    .flag_done_o(flag_done), .flag_cmp_o(flag_cmp), .irq_o(cmp_irq)
  );

  tsa_settle #(.SETTLE_CYC(SETTLE_CYC)) u_settle (
    .clk(clk), .rst_n(rst_n), .pwr_on_i(pwr_ok), .ready_o(settle_ok)
  );

  tsa_seq #(.CODE_W(CODE_W), .AVG_LOG_MAX(AVG_LOG_MAX)) u_seq (
    .clk(clk), .rst_n(rst_n),
    .start_i(start_evt), .abort_i(!pwr_ok), .cont_i(cont),
    .avg_log_i(avg_log), .use_avg_i(use_avg),
    .smp_vld_i(smp_vld), .smp_code_i(smp_code),
    .smp_req_o(smp_req), .busy_o(busy), .fin_o(fin_evt), .res_o(new_res)
  );
endmodule

// File: rtl/tsa_chk.sv
module tsa_chk (
  input logic clk,
  input logic rst_n,
  input logic start_evt,
  input logic fin_evt,
  input logic busy,
  input logic pwr_ok,
  input logic settle_ok,
  input logic flag_done,
  input logic flag_cmp,
  input logic cmp_en,
  input logic smp_req,
  input logic smp_vld
);
  // R3
  start_settled_chk: assert property (@(posedge clk) disable iff (!rst_n)
    start_evt |-> settle_ok);

  // R4
  start_idle_chk: assert property (@(posedge clk) disable iff (!rst_n)
    start_evt |-> !busy);

  // R4
  busy_source_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(busy) |-> $past(start_evt));

  // R7
  done_source_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(flag_done) |-> $past(fin_evt));

  // R8
  cmp_source_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(flag_cmp) |-> $past(fin_evt && cmp_en));

  // R11
  abort_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !pwr_ok |=> !busy);

  // R12
  fin_handshake_chk: assert property (@(posedge clk) disable iff (!rst_n)
    fin_evt |-> (smp_req && smp_vld));
endmodule

bind tsense_avg_ctrl tsa_chk u_chk (
  .clk(clk), .rst_n(rst_n), .start_evt(start_evt), .fin_evt(fin_evt),
  .busy(busy), .pwr_ok(pwr_ok), .settle_ok(settle_ok),
  .flag_done(flag_done), .flag_cmp(flag_cmp), .cmp_en(cmp_en),
  .smp_req(smp_req), .smp_vld(smp_vld)
);

// File: tb/test_tsense_avg_ctrl.sv
module test_tsense_avg_ctrl;
  localparam int CLK_PERIOD = 10;
  localparam int SETTLE     = 120;

  localparam logic [7:0] A_SUP = 8'h00, A_TRG = 8'h04, A_MODE = 8'h08,
                         A_RES = 8'h10, A_STAT = 8'h14, A_CMP = 8'h18,
                         A_LOW = 8'h1C, A_HIGH = 8'h20, A_FLG = 8'h30,
                         A_IEN = 8'h34, A_CLR = 8'h38;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        bus_sel = 1'b0;
  logic        bus_wr = 1'b0;
  logic [7:0]  bus_addr = '0;
  logic [31:0] bus_wdata = '0;
  logic [31:0] bus_rdata;
  logic        smp_req;
  logic        smp_vld = 1'b0;
  logic [11:0] smp_code = '0;
  logic        cmp_irq;

  int nchk = 0;
  int nfail = 0;
  int k = 0;
  int tick = 0;
  int seed = 0;
  int step = 0;
  bit finished = 0;

  tsense_avg_ctrl #(.SETTLE_CYC(SETTLE)) i_tsense_avg_ctrl (
    .clk(clk), .rst_n(rst_n), .bus_sel(bus_sel), .bus_wr(bus_wr),
    .bus_addr(bus_addr), .bus_wdata(bus_wdata), .bus_rdata(bus_rdata),
    .smp_req(smp_req), .smp_vld(smp_vld), .smp_code(smp_code),
    .cmp_irq(cmp_irq)
  );

  always #(CLK_PERIOD/2) clk = ~clk;

  function automatic int code_of(input int i);
    return (seed + i * step) & 12'hFFF;
  endfunction

  // ADC stub: offers a sample two cycles out of three while requested.
  always @(negedge clk) begin
    tick = tick + 1;
    if (smp_req && (tick % 3 != 2)) begin
      smp_vld  = 1'b1;
      smp_code = 12'(code_of(k));
    end else begin
      smp_vld = 1'b0;
    end
  end

  always @(posedge clk) begin
    if (smp_req && smp_vld) k = k + 1;
  end

  task automatic chk(input string tag, input int act, input int exp);
    nchk++;
    if (act !== exp) begin
      nfail++;
      $display("FAIL %s: actual %0d expected %0d", tag, act, exp);
    end
  endtask

  task automatic wr(input logic [7:0] a, input logic [31:0] d);
    @(negedge clk);
    bus_sel = 1'b1; bus_wr = 1'b1; bus_addr = a; bus_wdata = d;
    @(negedge clk);
    bus_sel = 1'b0; bus_wr = 1'b0;
  endtask

  task automatic rd(input logic [7:0] a, output logic [31:0] d);
    @(negedge clk);
    bus_sel = 1'b1; bus_wr = 1'b0; bus_addr = a;
    #1 d = bus_rdata;
    bus_sel = 1'b0;
  endtask

  task automatic wait_done(input string tag);
    logic [31:0] d;
    d = '0;
    for (int i = 0; i < 400; i++) begin
      rd(A_FLG, d);
      if (d[0]) break;
    end
    chk(tag, int'(d[0]), 1);
  endtask

  function automatic int exp_res(input int m, input int avg);
    int s;
    int n;
    n = 1 << m;
    s = 0;
    for (int i = 0; i < n; i++) s += code_of(i);
    return avg ? (s >> m) : code_of(n - 1);
  endfunction

  // One conversion with constant code v under 8-sample averaging.
  task automatic conv_const(input int v);
    seed = v; step = 0;
    wr(A_CLR, 32'h3);
    k = 0;
    wr(A_TRG, 32'h1);
    wait_done("R7 done for compare run");
  endtask

  initial begin : watchdog
    #(CLK_PERIOD * 150000);
    if (!finished) begin
      nfail++;
      $display("FAIL watchdog: actual running expected finished");
      $display("End of test - %0d assertions evaluated, %0d failures", nchk, nfail);
      $finish;
    end
  end

  initial begin : main
    logic [31:0] d;
    int seeds [3];
    int steps [3];
    int vals [7];
    int kk;
    seeds = '{37, 4095, 1000};
    steps = '{511, 0, 1234};
    vals  = '{99, 100, 150, 200, 201, 0, 4095};

    repeat (3) @(negedge clk);
    rst_n = 1'b1;

    // R1 reset state
    rd(A_SUP, d);  chk("R1 supply", int'(d), 0);
    rd(A_MODE, d); chk("R1 mode", int'(d), 0);
    rd(A_RES, d);  chk("R1 result", int'(d), 0);
    rd(A_STAT, d); chk("R1 status", int'(d), 0);
    rd(A_FLG, d);  chk("R1 flags", int'(d), 0);
    chk("R1 smp_req", int'(smp_req), 0);
    chk("R1 cmp_irq", int'(cmp_irq), 0);

    // R2 supply ordering rule
    wr(A_SUP, 32'h3); rd(A_SUP, d); chk("R2 bits without subsystem enable", int'(d), 0);
    wr(A_SUP, 32'h4); rd(A_SUP, d); chk("R2 subsystem enable alone", int'(d), 4);
    wr(A_SUP, 32'h7); rd(A_SUP, d); chk("R2 all three bits", int'(d), 7);

    // R3 power-down set: trigger ignored however long we wait
    wr(A_MODE, 32'h203);
    repeat (SETTLE + 30) @(negedge clk);
    wr(A_TRG, 32'h1); rd(A_STAT, d); chk("R3 trigger while powered down", int'(d[0]), 0);

    // R3 trigger inside the settling window is ignored
    wr(A_SUP, 32'h5);
    repeat (SETTLE - 20) @(negedge clk);
    wr(A_TRG, 32'h1); rd(A_STAT, d); chk("R3 trigger before settling", int'(d[0]), 0);
    repeat (30) @(negedge clk);
    seed = 5; step = 3; k = 0;
    wr(A_TRG, 32'h1); rd(A_STAT, d); chk("R3 trigger after settling", int'(d[0]), 1);
    wait_done("R7 done after settled start");
    chk("R12 sample count", k, 8);

    // R5 R6 R12 sweep over depth, output source and sample patterns
    for (int p = 0; p < 3; p++) begin
      for (int m = 0; m < 4; m++) begin
        for (int a = 0; a < 2; a++) begin
          seed = seeds[p]; step = steps[p];
          wr(A_CLR, 32'h1);
          wr(A_MODE, (a << 9) | m);
          k = 0;
          wr(A_TRG, 32'h1);
          if (m == 3) begin
            rd(A_STAT, d); chk("R4 busy during conversion", int'(d[0]), 1);
            chk("R12 smp_req while busy", int'(smp_req), 1);
            wr(A_TRG, 32'h1);  // R4: ignored while busy
          end
          wait_done("R7 done in sweep");
          rd(A_STAT, d); chk("R4 idle after done", int'(d[0]), 0);
          chk("R12 R4 samples per conversion", k, 1 << m);
          rd(A_RES, d);
          chk(a ? "R5 averaged result" : "R6 raw result", int'(d), exp_res(m, a));
        end
      end
    end

    // R8 window compare, limits inclusive
    wr(A_MODE, 32'h203);
    wr(A_LOW, 32'd100);
    wr(A_HIGH, 32'd200);
    wr(A_CMP, 32'h1);
    wr(A_IEN, 32'h2);
    foreach (vals[i]) begin
      conv_const(vals[i]);
      rd(A_FLG, d);
      chk("R8 compare flag", int'(d[1]), (vals[i] < 100 || vals[i] > 200) ? 1 : 0);
      chk("R9 irq follows flag", int'(cmp_irq), (vals[i] < 100 || vals[i] > 200) ? 1 : 0);
    end
    wr(A_CMP, 32'h0);
    conv_const(50);
    rd(A_FLG, d); chk("R8 compare disabled", int'(d[1]), 0);

    // R9 mask
    wr(A_CMP, 32'h1);
    wr(A_IEN, 32'h0);
    conv_const(250);
    rd(A_FLG, d); chk("R9 flag set while masked", int'(d[1]), 1);
    chk("R9 irq masked", int'(cmp_irq), 0);
    wr(A_IEN, 32'h2); chk("R9 irq unmasked", int'(cmp_irq), 1);

    // R7 selective clearing
    wr(A_CLR, 32'h2);
    rd(A_FLG, d); chk("R7 compare cleared", int'(d[1]), 0);
    chk("R7 done kept by compare clear", int'(d[0]), 1);
    chk("R9 irq after clear", int'(cmp_irq), 0);
    wr(A_CLR, 32'h0);
    rd(A_FLG, d); chk("R7 zero write keeps done", int'(d[0]), 1);
    wr(A_CLR, 32'h1);
    rd(A_FLG, d); chk("R7 done cleared", int'(d[0]), 0);

    // R10 continuous mode
    wr(A_CMP, 32'h0);
    seed = 777; step = 0; k = 0;
    wr(A_MODE, 32'h211);
    wr(A_TRG, 32'h1);
    wait_done("R10 first continuous result");
    wr(A_CLR, 32'h1);
    wait_done("R10 second continuous result");
    chk("R10 repeated sampling", (k >= 4) ? 1 : 0, 1);
    rd(A_RES, d); chk("R10 continuous result", int'(d), 777);
    wr(A_MODE, 32'h201);
    repeat (30) @(negedge clk);
    rd(A_STAT, d); chk("R10 stops after mode cleared", int'(d[0]), 0);
    kk = k;
    repeat (20) @(negedge clk);
    chk("R10 no further samples", k, kk);

    // R11 abort on power removal
    wr(A_CLR, 32'h3);
    wr(A_MODE, 32'h203);
    seed = 9; step = 1; k = 0;
    wr(A_TRG, 32'h1);
    wr(A_SUP, 32'h0);
    rd(A_STAT, d); chk("R11 busy cleared by power-off", int'(d[0]), 0);
    chk("R11 smp_req dropped", int'(smp_req), 0);
    repeat (20) @(negedge clk);
    rd(A_FLG, d); chk("R11 no done after abort", int'(d[0]), 0);

    finished = 1;
    $display("End of test - %0d assertions evaluated, %0d failures", nchk, nfail);
    $finish;
  end
endmodule